// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits between a local request port and an asynchronous NAND flash device with an 8-bit data bus. A requester asks for one of five operations: device reset, status read, page read, page program or block erase. The block then produces the complete strobe sequence on the flash pins. It drives the chip enable, the command-latch and address-latch enables, the write and read strobes, and the bidirectional data bus, which is split into an output, an output enable and an input. It then waits on the ready/busy line for the device to finish.

Page data passes through two byte-wide streams. A valid/ready stream feeds program data in. A valid-only stream carries read data and status bytes out. All device timing is counted in clock cycles from configuration inputs: strobe low and high widths, the gap from an output-select command to the first read strobe, the gap from the last address byte to the first data byte, and the longest allowed busy period. The block refuses every request except reset until a reset has completed. After a program or erase it reads the status byte itself and reports pass or fail with a completion pulse.

Top module: `nand_seq`

## Requirements
- R1: Until a reset operation has completed without timeout, a request with any op code other than reset (op 0) is dropped: no strobe is produced and `done` does not pulse. Before the first FFh command cycle, no other command byte is ever latched.
- R2: A reset request (op 0) produces exactly one command cycle carrying FFh. The block then waits for ready/busy to return high and pulses `done` with `fail` and `timeout_err` low.
- R3: A read request (op 2) produces, in order: command 00h; five address cycles (column low byte, column high byte, row bits 7:0, row bits 15:8, row bits 23:16); command 30h. After ready/busy returns high, it produces PAGE_BYTES (default 2112) read strobes, and each captured byte appears once on `rd_data` with `rd_valid`.
- R4: A program request (op 3) produces, in order: command 80h; the same five address cycles; PAGE_BYTES data cycles taking bytes from the write stream in arrival order; command 10h. After ready/busy returns high, it produces command 70h and one read strobe.
- R5: An erase request (op 4) produces, in order: command 60h; three address cycles (row bits 7:0, 15:8, 23:16); command D0h. After ready/busy returns high, it produces command 70h and one read strobe.
- R6: While the write strobe is low, a command cycle has command latch high and address latch low. An address cycle has address latch high and command latch low. A data cycle has both low. The write and read strobes are never low together, and chip enable is low whenever either strobe is low.
- R7: After a 70h or 30h command cycle, at least `cfg_twhr` clock cycles pass between the rising edge of that write strobe and the next falling edge of the read strobe.
- R8: In a program, at least `cfg_tadl` clock cycles pass between the rising edge of the last address strobe and the falling edge of the first data strobe.
- R9: Every write and read strobe stays low for exactly `cfg_lo` cycles, with 0 acting as 1, and stays high for at least `cfg_hi` cycles before the next strobe.
- R10: A status request (op 1) produces command 70h and one read strobe, returns the byte once on `rd_data` with `rd_valid`, then pulses `done`.
- R11: If ready/busy stays low for more than `cfg_busy_max` cycles of the busy wait, the operation ends with `done` and `timeout_err` high. The block is then idle and accepting requests again.
- R12: On completion of a program or erase, `fail` equals bit 0 of the status byte read back. Bit 0 high means the operation failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Op code: 0 reset, 1 status, 2 read, 3 program, 4 erase |
| req_col | input | 16 | Column address |
| req_row | input | 24 | Row address |
| req_ready | output | 1 | Block idle, request may be taken |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data available |
| wr_ready | output | 1 | Program byte taken on this cycle when valid |
| rd_data | output | 8 | Read page or status byte |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | With `done`: status bit 0 of program or erase |
| timeout_err | output | 1 | With `done`: busy wait expired |
| cfg_lo | input | PW_W | Strobe low width in cycles |
| cfg_hi | input | PW_W | Strobe high width in cycles |
| cfg_twhr | input | 8 | Cycles from output-select command to read strobe |
| cfg_tadl | input | 8 | Cycles from last address to first data |
| cfg_busy_max | input | TMR_W | Busy wait limit in cycles |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus input value |
| nand_rb_n | input | 1 | Ready/busy from the device, low when busy |

## Verification
The assertions assume that the configuration inputs stay constant while an operation is in flight. They also assume that the device pulls ready/busy low within a few cycles of a confirm or reset command, well inside the fixed settling window the block waits before sampling it. The stimulus writes configuration only while the block is idle. The bench's flash model lowers ready/busy one cycle after it sees a confirming write strobe. The model holds ready/busy low permanently only in the timeout scenario, so every other busy wait ends within the limit.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_STATUS = 3'd1,
    OP_READ   = 3'd2,
    OP_PROG   = 3'd3,
    OP_ERASE  = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_ADL, S_DIN, S_CMD2,
    S_WB, S_BUSY, S_STCMD, S_WHR, S_DOUT, S_FIN
  } st_e;

  localparam logic [7:0] OPC_RESET  = 8'hFF;
  localparam logic [7:0] OPC_STATUS = 8'h70;
  localparam logic [7:0] OPC_RD_SET = 8'h00;
  localparam logic [7:0] OPC_RD_GO  = 8'h30;
  localparam logic [7:0] OPC_PG_SET = 8'h80;
  localparam logic [7:0] OPC_PG_GO  = 8'h10;
  localparam logic [7:0] OPC_ER_SET = 8'h60;
  localparam logic [7:0] OPC_ER_GO  = 8'hD0;
endpackage

// File: rtl/nand_sync2.sv
module nand_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {2{RST_VAL}};
    else        stage_q <= {stage_q[0], d};
  end

  assign q = stage_q[1];
endmodule

// File: rtl/nand_strobe.sv
module nand_strobe #(
  parameter int PW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd,
  input  logic [PW_W-1:0] lo,
  input  logic [PW_W-1:0] hi,
  output logic            we_n,
  output logic            re_n,
  output logic            sample,
  output logic            fin,
  output logic            busy
);
  logic            busy_q, busy_n, ph_q, ph_n, rd_q, rd_n;
  logic [PW_W-1:0] cnt_q, cnt_n, lo_m1, hi_m1;

  assign lo_m1 = (lo == '0) ? '0 : lo - PW_W'(1);
  assign hi_m1 = (hi == '0) ? '0 : hi - PW_W'(1);

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    rd_n   = rd_q;
    cnt_n  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        ph_n   = 1'b0;
        rd_n   = rd;
        cnt_n  = lo_m1;
      end
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - PW_W'(1);
    end else if (!ph_q) begin
      ph_n  = 1'b1;
      cnt_n = hi_m1;
    end else begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      rd_q   <= rd_n;
      cnt_q  <= cnt_n;
    end
  end

  assign we_n   = !(busy_q && !ph_q && !rd_q);
  assign re_n   = !(busy_q && !ph_q && rd_q);
  assign sample = busy_q && !ph_q && rd_q && (cnt_q == '0);
  assign fin    = busy_q && ph_q && (cnt_q == '0);
  assign busy   = busy_q;
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int PW_W       = 4,
  parameter int TMR_W      = 24,
  parameter int WB_CYC     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [15:0]      req_col,
  input  logic [23:0]      req_row,
  output logic             req_ready,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             fail,
  output logic             timeout_err,
  input  logic [PW_W-1:0]  cfg_lo,
  input  logic [PW_W-1:0]  cfg_hi,
  input  logic [7:0]       cfg_twhr,
  input  logic [7:0]       cfg_tadl,
  input  logic [TMR_W-1:0] cfg_busy_max,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_n
);
  localparam int BC_W = $clog2(PAGE_BYTES + 1);
  localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(PAGE_BYTES - 1);

  st_e             st_q, st_n;
  op_e             op_q;
  logic [15:0]     col_q;
  logic [23:0]     row_q;
  logic [2:0]      aidx_q;
  logic [BC_W-1:0] bcnt_q;
  logic [TMR_W-1:0] wcnt_q;
  logic            inited_q, done_q, fail_q, tmo_q, rdv_q;
  logic [7:0]      rdd_q, dq_q, dq_sel;
  logic            srst_n, rb_s, accept, strobe_st, stb_start;
  logic            stb_fin, stb_sample, stb_busy, busy_expired;

  nand_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(srst_n));
  nand_sync2 #(.RST_VAL(1'b0)) u_rb_sync (
    .clk(clk), .rst_n(srst_n), .d(nand_rb_n), .q(rb_s));

  assign strobe_st = (st_q == S_CMD1) || (st_q == S_ADDR) || (st_q == S_DIN) ||
                     (st_q == S_CMD2) || (st_q == S_STCMD) || (st_q == S_DOUT);
  assign stb_start = strobe_st && !stb_busy && ((st_q != S_DIN) || wr_valid);

  nand_strobe #(.PW_W(PW_W)) u_strobe (
    .clk(clk), .rst_n(srst_n), .start(stb_start), .rd(st_q == S_DOUT),
    .lo(cfg_lo), .hi(cfg_hi), .we_n(nand_we_n), .re_n(nand_re_n),
    .sample(stb_sample), .fin(stb_fin), .busy(stb_busy));

  assign accept = (st_q == S_IDLE) && req_valid &&
                  (inited_q || (op_e'(req_op) == OP_RESET));
  assign busy_expired = !rb_s && (wcnt_q == cfg_busy_max);

  // byte presented on the bus for the strobe about to start
  always_comb begin
    dq_sel = wr_data;
    case (st_q)
      S_CMD1: case (op_q)
                OP_RESET: dq_sel = OPC_RESET;
                OP_READ:  dq_sel = OPC_RD_SET;
                OP_PROG:  dq_sel = OPC_PG_SET;
                default:  dq_sel = OPC_ER_SET;
              endcase
      S_CMD2: case (op_q)
                OP_READ: dq_sel = OPC_RD_GO;
                OP_PROG: dq_sel = OPC_PG_GO;
                default: dq_sel = OPC_ER_GO;
              endcase
      S_STCMD: dq_sel = OPC_STATUS;
      S_ADDR: case (aidx_q)
                3'd0:    dq_sel = col_q[7:0];
                3'd1:    dq_sel = col_q[15:8];
                3'd2:    dq_sel = row_q[7:0];
                3'd3:    dq_sel = row_q[15:8];
                default: dq_sel = row_q[23:16];
              endcase
      default: dq_sel = wr_data;
    endcase
  end

  always_comb begin
    st_n = st_q;
    case (st_q)
      S_IDLE:  if (accept) st_n = (op_e'(req_op) == OP_STATUS) ? S_STCMD : S_CMD1;
      S_CMD1:  if (stb_fin) st_n = (op_q == OP_RESET) ? S_WB : S_ADDR;
      S_ADDR:  if (stb_fin && aidx_q == 3'd4) st_n = (op_q == OP_PROG) ? S_ADL : S_CMD2;
      S_ADL:   if (wcnt_q == TMR_W'(cfg_tadl)) st_n = S_DIN;
      S_DIN:   if (stb_fin && bcnt_q == LAST_BYTE) st_n = S_CMD2;
      S_CMD2:  if (stb_fin) st_n = S_WB;
      S_WB:    if (wcnt_q == TMR_W'(WB_CYC - 1)) st_n = S_BUSY;
      S_BUSY:  if (rb_s) st_n = (op_q == OP_READ) ? S_WHR :
                                (op_q == OP_RESET) ? S_FIN : S_STCMD;
               else if (busy_expired) st_n = S_FIN;
      S_STCMD: if (stb_fin) st_n = S_WHR;
      S_WHR:   if (wcnt_q == TMR_W'(cfg_twhr)) st_n = S_DOUT;
      S_DOUT:  if (stb_fin && (op_q != OP_READ || bcnt_q == LAST_BYTE)) st_n = S_FIN;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q     <= S_IDLE;
      op_q     <= OP_RESET;
      col_q    <= '0;
      row_q    <= '0;
      aidx_q   <= '0;
      bcnt_q   <= '0;
      wcnt_q   <= '0;
      inited_q <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      tmo_q    <= 1'b0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
      dq_q     <= '0;
    end else begin
      st_q   <= st_n;
      done_q <= (st_q == S_FIN);
      rdv_q  <= stb_sample && (op_q == OP_READ || op_q == OP_STATUS);
      if (accept) begin
        op_q   <= op_e'(req_op);
        col_q  <= req_col;
        row_q  <= req_row;
        aidx_q <= (op_e'(req_op) == OP_ERASE) ? 3'd2 : 3'd0;
        fail_q <= 1'b0;
        tmo_q  <= 1'b0;
      end else if (st_q == S_ADDR && stb_fin) begin
        aidx_q <= aidx_q + 3'd1;
      end
      if (st_n != st_q)                                 wcnt_q <= '0;
      else if (st_q inside {S_ADL, S_WB, S_BUSY, S_WHR}) wcnt_q <= wcnt_q + TMR_W'(1);
      if (st_n != st_q)                                 bcnt_q <= '0;
      else if (stb_fin && st_q inside {S_DIN, S_DOUT})   bcnt_q <= bcnt_q + BC_W'(1);
      if (stb_start) dq_q <= dq_sel;
      if (stb_sample) begin
        rdd_q <= nand_dq_i;
        if (op_q == OP_PROG || op_q == OP_ERASE) fail_q <= nand_dq_i[0];
      end
      if (st_q == S_BUSY && busy_expired) tmo_q <= 1'b1;
      if (st_q == S_FIN && op_q == OP_RESET && !tmo_q) inited_q <= 1'b1;
    end
  end

  assign req_ready   = (st_q == S_IDLE);
  assign wr_ready    = (st_q == S_DIN) && !stb_busy;
  assign rd_data     = rdd_q;
  assign rd_valid    = rdv_q;
  assign done        = done_q;
  assign fail        = done_q && fail_q;
  assign timeout_err = done_q && tmo_q;
  assign nand_ce_n   = (st_q == S_IDLE);
  assign nand_cle    = (st_q == S_CMD1) || (st_q == S_CMD2) || (st_q == S_STCMD);
  assign nand_ale    = (st_q == S_ADDR);
  assign nand_dq_o   = dq_q;
  assign nand_dq_oe  = (st_q == S_CMD1) || (st_q == S_ADDR) || (st_q == S_DIN) ||
                       (st_q == S_CMD2) || (st_q == S_STCMD);
endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_ce_n,
  input logic [7:0] nand_dq_o,
  input logic       done,
  input logic       timeout_err,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       wr_ready
);
  logic ff_sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_sent_q <= 1'b0;
    else if (!nand_we_n && nand_cle && nand_dq_o == 8'hFF) ff_sent_q <= 1'b1;
  end

  // R1: the first command latched after power-up is the reset opcode
  assert_first_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && nand_cle && !ff_sent_q) |-> (nand_dq_o == 8'hFF));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_latch_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> !(nand_cle && nand_ale));

  assert_ce_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_rd_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!nand_re_n));

  assert_wr_idle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> nand_we_n);

  assert_tmo_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (done && req_ready));
endmodule

bind nand_seq nand_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n),
  .nand_dq_o(nand_dq_o), .done(done), .timeout_err(timeout_err),
  .req_ready(req_ready), .rd_valid(rd_valid), .wr_ready(wr_ready));

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
  localparam int PAGE = 2112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_col = '0;
  logic [23:0] req_row = '0;
  logic        req_ready, wr_ready, rd_valid, done, fail, timeout_err;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data, rd_data;
  logic [3:0]  cfg_lo = 4'd2, cfg_hi = 4'd2;
  logic [7:0]  cfg_twhr = 8'd20, cfg_tadl = 8'd16;
  logic [23:0] cfg_busy_max = 24'd5000;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb_n;

  nand_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_col(req_col), .req_row(req_row), .req_ready(req_ready),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .fail(fail),
    .timeout_err(timeout_err), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_twhr(cfg_twhr), .cfg_tadl(cfg_tadl), .cfg_busy_max(cfg_busy_max),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n));

  int tests_run = 0;
  int tests_failed = 0;

  // flash model settings, written only by the test flow
  logic [7:0] status_val = 8'hE0;
  int         busy_len = 40;
  logic       stuck = 1'b0;

  // write stream source
  int wr_idx = 0;
  assign wr_data = 8'(wr_idx * 5 + 1);
  always @(posedge clk) if (wr_valid && wr_ready) wr_idx <= wr_idx + 1;

  // flash model and bus monitor
  int   cyc = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  int   we_fall = 0, re_fall = 0;
  int   stb_cnt = 0, width_err = 0, hi_err = 0;
  int   last_rise = 0;
  logic [8:0] log_q [0:127];
  int   log_n = 0;
  int   din_cnt = 0, din_pos = 0, din_err = 0;
  int   prev_kind = 0;
  int   adl_gap = -1, whr_gap = -1, whr_ref = 0;
  logic whr_armed = 1'b0;
  int   rd_idx = 0, busy_cnt = 0;
  logic mode_status = 1'b0;

  assign nand_rb_n = !stuck && (busy_cnt == 0);
  assign nand_dq_i = mode_status ? status_val : 8'(rd_idx * 7 + 3);

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if ((prev_we && !nand_we_n) || (prev_re && !nand_re_n)) begin
      if (stb_cnt > 0 && (cyc - last_rise) < int'(cfg_hi)) hi_err = hi_err + 1;
      stb_cnt = stb_cnt + 1;
    end
    if (prev_we && !nand_we_n) begin
      we_fall = cyc;
      if (!nand_cle && !nand_ale && prev_kind == 2) adl_gap = cyc - last_rise;
    end
    if (!prev_we && nand_we_n) begin
      if ((cyc - we_fall) != int'(cfg_lo)) width_err = width_err + 1;
      last_rise = cyc;
      if (nand_cle && !nand_ale) begin
        if (log_n < 128) log_q[log_n] = {1'b1, nand_dq_o};
        log_n = log_n + 1;
        prev_kind = 1;
        if (nand_dq_o == 8'h70 || nand_dq_o == 8'h30) begin
          whr_armed = 1'b1;
          whr_ref = cyc;
          mode_status <= (nand_dq_o == 8'h70);
          rd_idx <= 0;
        end
        if (nand_dq_o == 8'h80) din_pos = 0;
        if (nand_dq_o == 8'hFF || nand_dq_o == 8'h30 ||
            nand_dq_o == 8'h10 || nand_dq_o == 8'hD0) busy_cnt <= busy_len;
      end else if (nand_ale && !nand_cle) begin
        if (log_n < 128) log_q[log_n] = {1'b0, nand_dq_o};
        log_n = log_n + 1;
        prev_kind = 2;
      end else begin
        if (nand_dq_o != 8'(din_pos * 5 + 1)) din_err = din_err + 1;
        din_pos = din_pos + 1;
        din_cnt = din_cnt + 1;
        prev_kind = 3;
      end
    end
    if (prev_re && !nand_re_n) begin
      re_fall = cyc;
      if (whr_armed) begin
        whr_gap = cyc - whr_ref;
        whr_armed = 1'b0;
      end
    end
    if (!prev_re && nand_re_n) begin
      if ((cyc - re_fall) != int'(cfg_lo)) width_err = width_err + 1;
      last_rise = cyc;
      rd_idx <= rd_idx + 1;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests_run = tests_run + 1;
    if (!ok) begin
      tests_failed = tests_failed + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_log(input int base, input int idx, input logic [8:0] exp, input string tag);
    logic [8:0] act;
    act = (base + idx < 128) ? log_q[base + idx] : 9'h1FF;
    check(act == exp, tag, int'(act), int'(exp));
  endtask

  // issue one request and wait for completion, collecting read bytes
  task automatic run_op(input logic [2:0] op, input logic [15:0] col, input logic [23:0] row,
                        input int maxc, output logic got, output logic f, output logic t,
                        output int nrd, output int nerr, output logic [7:0] lastb);
    got = 1'b0; f = 1'b0; t = 1'b0; nrd = 0; nerr = 0; lastb = 8'h00;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_col = col; req_row = row; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < maxc && !got; i++) begin
      if (rd_valid) begin
        if (rd_data != 8'(nrd * 7 + 3)) nerr = nerr + 1;
        lastb = rd_data;
        nrd = nrd + 1;
      end
      if (done) begin
        got = 1'b1; f = fail; t = timeout_err;
      end
      if (!got) @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    check(nand_ce_n && nand_we_n && nand_re_n && !nand_dq_oe, "reset pins idle", 
          int'({nand_ce_n, nand_we_n, nand_re_n, nand_dq_oe}), 4'b1110);
    check(req_ready && !done && !rd_valid, "reset outputs", int'({req_ready, done, rd_valid}), 3'b100);
  endtask

  task automatic t_refuse_R1();
    int s0;
    logic seen_done;
    s0 = stb_cnt;
    seen_done = 1'b0;
    @(negedge clk);
    req_op = 3'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done) seen_done = 1'b1;
      @(negedge clk);
    end
    check(stb_cnt == s0, "R1 no strobe before reset", stb_cnt - s0, 0);
    check(!seen_done && req_ready, "R1 no done before reset", int'(seen_done), 0);
  endtask

  task automatic t_reset_R2();
    int base, nrd, nerr;
    logic got, f, t;
    logic [7:0] lb;
    base = log_n;
    run_op(3'd0, 16'h0, 24'h0, 3000, got, f, t, nrd, nerr, lb);
    check(got && !f && !t, "R2 reset done", int'({got, f, t}), 3'b100);
    check(log_n - base == 1, "R2 one cycle", log_n - base, 1);
    chk_log(base, 0, 9'h1FF, "R2 opcode FF");
  endtask

  task automatic t_status_R10();
    int base, nrd, nerr;
    logic got, f, t;
    logic [7:0] lb;
    base = log_n;
    status_val = 8'hC4;
    run_op(3'd1, 16'h0, 24'h0, 3000, got, f, t, nrd, nerr, lb);
    check(got && nrd == 1, "R10 status one byte", nrd, 1);
    check(lb == 8'hC4, "R10 status value", int'(lb), 8'hC4);
    chk_log(base, 0, 9'h170, "R10 opcode 70");
    check(whr_gap >= int'(cfg_twhr), "R7 gap after 70h", whr_gap, int'(cfg_twhr));
    status_val = 8'hE0;
  endtask

  task automatic t_read_R3();
    int base, nrd, nerr, w0, h0;
    logic got, f, t;
    logic [7:0] lb;
    base = log_n; w0 = width_err; h0 = hi_err;
    run_op(3'd2, 16'h0456, 24'h012345, 40000, got, f, t, nrd, nerr, lb);
    check(got && !t, "R3 read done", int'(got), 1);
    check(log_n - base == 7, "R3 cycle count", log_n - base, 7);
    chk_log(base, 0, 9'h100, "R3 opcode 00");
    chk_log(base, 1, 9'h056, "R3 col lo");
    chk_log(base, 2, 9'h004, "R3 col hi");
    chk_log(base, 3, 9'h045, "R3 row 0");
    chk_log(base, 4, 9'h023, "R3 row 1");
    chk_log(base, 5, 9'h001, "R3 row 2");
    chk_log(base, 6, 9'h130, "R3 opcode 30");
    check(nrd == PAGE, "R3 byte count", nrd, PAGE);
    check(nerr == 0, "R3 byte values", nerr, 0);
    check(whr_gap >= int'(cfg_twhr), "R7 gap after 30h", whr_gap, int'(cfg_twhr));
    check(width_err == w0, "R9 low width", width_err - w0, 0);
    check(hi_err == h0, "R9 high width", hi_err - h0, 0);
  endtask

  task automatic t_prog_R4();
    int base, nrd, nerr, d0, e0;
    logic got, f, t;
    logic [7:0] lb;
    base = log_n; d0 = din_cnt; e0 = din_err;
    wr_valid = 1'b1;
    run_op(3'd3, 16'h0456, 24'h012345, 40000, got, f, t, nrd, nerr, lb);
    wr_valid = 1'b0;
    check(got && !t, "R4 program done", int'(got), 1);
    check(log_n - base == 8, "R4 cycle count", log_n - base, 8);
    chk_log(base, 0, 9'h180, "R4 opcode 80");
    chk_log(base, 1, 9'h056, "R4 col lo");
    chk_log(base, 5, 9'h001, "R4 row 2");
    chk_log(base, 6, 9'h110, "R4 opcode 10");
    chk_log(base, 7, 9'h170, "R4 status 70");
    check(din_cnt - d0 == PAGE, "R4 data count", din_cnt - d0, PAGE);
    check(din_err == e0, "R4 data order", din_err - e0, 0);
    check(adl_gap >= int'(cfg_tadl), "R8 address to data gap", adl_gap, int'(cfg_tadl));
    check(!f && nrd == 0, "R12 program pass", int'(f), 0);
  endtask

  task automatic t_erase_R5();
    int base, nrd, nerr;
    logic got, f, t;
    logic [7:0] lb;
    base = log_n;
    status_val = 8'hE1;
    run_op(3'd4, 16'hFFFF, 24'h000ABC, 4000, got, f, t, nrd, nerr, lb);
    check(got && !t, "R5 erase done", int'(got), 1);
    check(log_n - base == 6, "R5 cycle count", log_n - base, 6);
    chk_log(base, 0, 9'h160, "R5 opcode 60");
    chk_log(base, 1, 9'h0BC, "R5 row 0");
    chk_log(base, 2, 9'h00A, "R5 row 1");
    chk_log(base, 3, 9'h000, "R5 row 2");
    chk_log(base, 4, 9'h1D0, "R5 opcode D0");
    chk_log(base, 5, 9'h170, "R5 status 70");
    check(f, "R12 erase fail bit", int'(f), 1);
    status_val = 8'hE0;
  endtask

  task automatic t_timeout_R11();
    int nrd, nerr;
    logic got, f, t;
    logic [7:0] lb;
    stuck = 1'b1;
    cfg_busy_max = 24'd300;
    run_op(3'd4, 16'h0, 24'h000010, 3000, got, f, t, nrd, nerr, lb);
    check(got && t, "R11 timeout flagged", int'({got, t}), 2'b11);
    @(negedge clk);
    check(req_ready, "R11 idle after timeout", int'(req_ready), 1);
    stuck = 1'b0;
    cfg_busy_max = 24'd5000;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_width_R9();
    int nrd, nerr, w0;
    logic got, f, t;
    logic [7:0] lb;
    cfg_lo = 4'd4;
    cfg_hi = 4'd3;
    w0 = width_err;
    run_op(3'd1, 16'h0, 24'h0, 3000, got, f, t, nrd, nerr, lb);
    check(got && nrd == 1, "R9 op with wide strobes", nrd, 1);
    check(width_err == w0, "R9 low width 4", width_err - w0, 0);
    cfg_lo = 4'd2;
    cfg_hi = 4'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_failed = tests_failed + 1;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset_state();
    t_refuse_R1();
    t_reset_R2();
    t_status_R10();
    t_read_R3();
    t_prog_R4();
    t_erase_R5();
    t_timeout_R11();
    t_width_R9();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule